// File: doc/BRIEF.md
# Sleep Mode Clock Controller

This block is the power-management sequencer of a small microcontroller. While the device runs, every clock domain is enabled. When software raises a sleep request, the controller captures a 3-bit mode code and drops a set of clock-domain enables: CPU, I/O peripherals, ADC, asynchronous timer and main oscillator. The set it drops depends on the mode. In each mode only some wake sources are honoured. When one of those arrives, the controller returns to the running state. If the mode stopped the main oscillator, it first waits for the oscillator to report ready.

The mode code is captured at the moment the request is accepted, so later changes on the mode input have no effect until the next sleep. The enables are decoded from registered state only, so a wake pulse never reaches a clock enable combinationally. A synchronous reset always returns the block to the running state with every domain on.

Top module: `slp_clock_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it falls, all five enables and `awake` are 1. This holds even when reset arrives during sleep.
- R2: A sleep request is accepted only while `awake` is 1. `awake` and `clk_cpu_en` are 0 from the cycle after acceptance. A request raised while asleep or waiting for the oscillator has no effect.
- R3: Mode 000 (full idle) stops only the CPU. I/O, ADC, async timer and oscillator stay enabled, and all four wake sources are honoured.
- R4: Mode 001 (ADC quiet) stops the CPU and I/O. ADC, async timer and oscillator stay enabled, and all four wake sources are honoured.
- R5: Mode 010 (deep off) turns off all five enables. Only the external interrupt and the hardware-reset wake source are honoured.
- R6: Mode 011 (timekeeping off) keeps only the async timer enabled. The external interrupt, hardware-reset and timer-interrupt sources are honoured.
- R7: Mode 110 (oscillator hold) keeps only the oscillator enabled. The external interrupt and hardware-reset sources are honoured.
- R8: Mode 111 (oscillator and timer hold) keeps the oscillator and async timer enabled. The external interrupt, hardware-reset and timer-interrupt sources are honoured.
- R9: Reserved codes 100 and 101 behave exactly like mode 000.
- R10: A wake source not honoured in the captured mode leaves every output unchanged.
- R11: Waking from 010 or 011 first enables only the oscillator, in addition to whatever was on. The CPU stays off until `osc_ready` is seen high. All enables and `awake` go to 1 in the cycle after that. At least one wait cycle always occurs, even when `osc_ready` is already high.
- R12: Waking from a mode that keeps the oscillator running sets all enables and `awake` to 1 in the cycle after the wake source is seen.
- R13: Changes on `mode_sel` while asleep have no effect on the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to enter the selected sleep mode |
| mode_sel | input | 3 | Sleep mode code |
| wake_ext | input | 1 | External interrupt wake source |
| wake_hwrst | input | 1 | Hardware-reset wake source |
| wake_periph | input | 1 | Peripheral interrupt wake source |
| wake_timer | input | 1 | Asynchronous timer interrupt wake source |
| osc_ready | input | 1 | Main oscillator is stable |
| clk_cpu_en | output | 1 | CPU clock enable |
| clk_io_en | output | 1 | I/O peripheral clock enable |
| clk_adc_en | output | 1 | ADC clock enable |
| clk_async_en | output | 1 | Asynchronous timer clock enable |
| osc_en | output | 1 | Main oscillator enable |
| awake | output | 1 | Controller is in the running state |

## Verification
The hardest state to reach is the oscillator wait in its corner forms. One form is `osc_ready` already high when the wake arrives, which must still cost one wait cycle. The other is `osc_ready` held low for several cycles, during which the CPU must stay off. The stimulus enters the oscillator-stopping modes, pulses a permitted source, and then controls `osc_ready` cycle by cycle. Before any permitted source, every forbidden source is pulsed alone in each mode, with the mode input changed and a second sleep request raised while asleep, to show that none of these moves the enables.

// File: rtl/slp_pkg.sv
package slp_pkg;

    localparam int MODE_W = 3;
    localparam int N_WAKE = 4;

    localparam int WK_EXT    = 0;
    localparam int WK_HWRST  = 1;
    localparam int WK_PERIPH = 2;
    localparam int WK_TIMER  = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_IDLE  = 3'b000,
        MODE_ADCQ  = 3'b001,
        MODE_DEEP  = 3'b010,
        MODE_TKEEP = 3'b011,
        MODE_OHOLD = 3'b110,
        MODE_OTHLD = 3'b111
    } slp_mode_e;

    typedef enum logic [1:0] {
        ST_RUN      = 2'b00,
        ST_SLEEP    = 2'b01,
        ST_OSC_WAIT = 2'b10
    } slp_state_e;

    typedef struct packed {
        logic cpu;
        logic io;
        logic adc;
        logic tmr_async;
        logic osc;
    } dom_en_t;

    localparam dom_en_t DOM_ALL_ON = '{cpu: 1'b1, io: 1'b1, adc: 1'b1, tmr_async: 1'b1, osc: 1'b1};

    // Fold the raw code into a legal mode; unused codes fall back to idle.
    function automatic slp_mode_e norm_mode(input logic [MODE_W-1:0] raw);
        case (raw)
            3'b001:  return MODE_ADCQ;
            3'b010:  return MODE_DEEP;
            3'b011:  return MODE_TKEEP;
            3'b110:  return MODE_OHOLD;
            3'b111:  return MODE_OTHLD;
            default: return MODE_IDLE;
        endcase
    endfunction

    // Domains left running while asleep in a given mode.
    function automatic dom_en_t sleep_domains(input slp_mode_e m);
        dom_en_t d;
        d = '0;
        case (m)
            MODE_IDLE:  begin d.io = 1'b1; d.adc = 1'b1; d.tmr_async = 1'b1; d.osc = 1'b1; end
            MODE_ADCQ:  begin d.adc = 1'b1; d.tmr_async = 1'b1; d.osc = 1'b1; end
            MODE_TKEEP: d.tmr_async = 1'b1;
            MODE_OHOLD: d.osc = 1'b1;
            MODE_OTHLD: begin d.osc = 1'b1; d.tmr_async = 1'b1; end
            default:    d = '0;
        endcase
        return d;
    endfunction

    // Wake sources honoured in a given mode, indexed by WK_*.
    function automatic logic [N_WAKE-1:0] wake_mask(input slp_mode_e m);
        logic [N_WAKE-1:0] w;
        w = '0;
        w[WK_EXT]   = 1'b1;
        w[WK_HWRST] = 1'b1;
        case (m)
            MODE_IDLE, MODE_ADCQ: begin
                w[WK_PERIPH] = 1'b1;
                w[WK_TIMER]  = 1'b1;
            end
            MODE_TKEEP, MODE_OTHLD: w[WK_TIMER] = 1'b1;
            default: ;
        endcase
        return w;
    endfunction

    function automatic logic osc_stops(input slp_mode_e m);
        dom_en_t d;
        d = sleep_domains(m);
        return ~d.osc;
    endfunction

endpackage

// File: rtl/slp_mode_latch.sv
module slp_mode_latch
    import slp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [MODE_W-1:0] mode_raw,
    output slp_mode_e         mode_q
);

    always_ff @(posedge clk) begin
        if (rst)       mode_q <= MODE_IDLE;
        else if (load) mode_q <= norm_mode(mode_raw);
    end

    // R13: the captured mode only moves when the sequencer accepts a request
    assert_mode_held_R13: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(mode_q));

endmodule

// File: rtl/slp_wake_gate.sv
module slp_wake_gate
    import slp_pkg::*;
(
    input  slp_mode_e         mode,
    input  logic [N_WAKE-1:0] wake_src,
    output logic              wake_hit
);

    logic [N_WAKE-1:0] allow;
    logic [N_WAKE-1:0] hit;

    assign allow = wake_mask(mode);

    for (genvar i = 0; i < N_WAKE; i++) begin : g_src
        assign hit[i] = wake_src[i] & allow[i];
    end

    assign wake_hit = |hit;

endmodule

// File: rtl/slp_seq_fsm.sv
module slp_seq_fsm
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  logic       wake_hit,
    input  logic       osc_stop,
    input  logic       osc_ready,
    output slp_state_e state,
    output logic       load
);

    slp_state_e nxt;

    assign load = (state == ST_RUN) && sleep_req;

    always_comb begin
        nxt = state;
        case (state)
            ST_RUN:      if (sleep_req) nxt = ST_SLEEP;
            ST_SLEEP:    if (wake_hit)  nxt = osc_stop ? ST_OSC_WAIT : ST_RUN;
            ST_OSC_WAIT: if (osc_ready) nxt = ST_RUN;
            default:     nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= nxt;
    end

    // R2: an accepted request leaves the running state on the next edge
    assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> state == ST_SLEEP);

    // R10: without an honoured source the sleep state persists
    assert_ignore_wake_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && !wake_hit) |=> state == ST_SLEEP);

    // R11: no return to running before the oscillator is ready
    assert_osc_wait_R11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OSC_WAIT && !osc_ready) |=> state == ST_OSC_WAIT);

    // R11: an oscillator-stopping mode never skips the wait state
    assert_osc_path_R11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && wake_hit && osc_stop) |=> state == ST_OSC_WAIT);

    // R12: an oscillator-keeping mode wakes straight to running
    assert_fast_wake_R12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && wake_hit && !osc_stop) |=> state == ST_RUN);

endmodule

// File: rtl/slp_clock_ctrl.sv
module slp_clock_ctrl
    import slp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_req,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              wake_ext,
    input  logic              wake_hwrst,
    input  logic              wake_periph,
    input  logic              wake_timer,
    input  logic              osc_ready,
    output logic              clk_cpu_en,
    output logic              clk_io_en,
    output logic              clk_adc_en,
    output logic              clk_async_en,
    output logic              osc_en,
    output logic              awake
);

    slp_mode_e         mode_q;
    slp_state_e        state;
    logic              load;
    logic              wake_hit;
    logic [N_WAKE-1:0] wake_src;
    dom_en_t           dom;

    always_comb begin
        wake_src             = '0;
        wake_src[WK_EXT]     = wake_ext;
        wake_src[WK_HWRST]   = wake_hwrst;
        wake_src[WK_PERIPH]  = wake_periph;
        wake_src[WK_TIMER]   = wake_timer;
    end

    slp_mode_latch u_mode (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .mode_raw (mode_sel),
        .mode_q   (mode_q)
    );

    slp_wake_gate u_gate (
        .mode     (mode_q),
        .wake_src (wake_src),
        .wake_hit (wake_hit)
    );

    slp_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .wake_hit  (wake_hit),
        .osc_stop  (osc_stops(mode_q)),
        .osc_ready (osc_ready),
        .state     (state),
        .load      (load)
    );

    // Enables come from registered state and mode only.
    always_comb begin
        case (state)
            ST_SLEEP:    dom = sleep_domains(mode_q);
            ST_OSC_WAIT: begin
                dom     = sleep_domains(mode_q);
                dom.osc = 1'b1;
            end
            default:     dom = DOM_ALL_ON;
        endcase
    end

    assign clk_cpu_en   = dom.cpu;
    assign clk_io_en    = dom.io;
    assign clk_adc_en   = dom.adc;
    assign clk_async_en = dom.tmr_async;
    assign osc_en       = dom.osc;
    assign awake        = (state == ST_RUN);

    // R1: the cycle after reset every domain runs
    assert_reset_on_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (awake && clk_cpu_en && clk_io_en && clk_adc_en && clk_async_en && osc_en));

    // R2: the CPU clock never runs while asleep
    assert_cpu_off_R2: assert property (@(posedge clk) disable iff (rst)
        !awake |-> !clk_cpu_en);

    // R11: the oscillator is on whenever the CPU clock is
    assert_osc_before_cpu_R11: assert property (@(posedge clk) disable iff (rst)
        clk_cpu_en |-> osc_en);

endmodule

// File: tb/slp_clock_ctrl_test.sv
`timescale 1ns/1ps
module slp_clock_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_req = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic [3:0] wk = 4'b0000; // {timer, periph, hwrst, ext}
    logic       osc_ready = 1'b0;
    logic       clk_cpu_en, clk_io_en, clk_adc_en, clk_async_en, osc_en, awake;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    slp_clock_ctrl uut (
        .clk          (clk),
        .rst          (rst),
        .sleep_req    (sleep_req),
        .mode_sel     (mode_sel),
        .wake_ext     (wk[0]),
        .wake_hwrst   (wk[1]),
        .wake_periph  (wk[2]),
        .wake_timer   (wk[3]),
        .osc_ready    (osc_ready),
        .clk_cpu_en   (clk_cpu_en),
        .clk_io_en    (clk_io_en),
        .clk_adc_en   (clk_adc_en),
        .clk_async_en (clk_async_en),
        .osc_en       (osc_en),
        .awake        (awake)
    );

    // {cpu, io, adc, async, osc, awake}
    function automatic logic [5:0] obs();
        return {clk_cpu_en, clk_io_en, clk_adc_en, clk_async_en, osc_en, awake};
    endfunction

    // Sleep domain mask {cpu, io, adc, async, osc} per requirements R3..R9
    function automatic logic [4:0] exp_mask(input int m);
        case (m)
            1:       return 5'b00111;
            2:       return 5'b00000;
            3:       return 5'b00010;
            6:       return 5'b00001;
            7:       return 5'b00011;
            default: return 5'b01111;
        endcase
    endfunction

    // Honoured sources {timer, periph, hwrst, ext}
    function automatic logic [3:0] exp_wake(input int m);
        case (m)
            2, 6:    return 4'b0011;
            3, 7:    return 4'b1011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic string tag_of(input int m);
        case (m)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            6: return "R7";
            7: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [5:0] exp);
        n_tests++;
        if (obs() !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs %b expected %b", req, obs(), exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sleep_req = 1'b0; wk = '0; osc_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic enter_sleep(input int m);
        @(negedge clk);
        mode_sel  = 3'(m);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", 6'b111111);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 6'b111111);
    endtask

    // Enter a mode, try forbidden sources, then wake with a permitted one.
    task automatic t_mode(input int m);
        string t;
        logic [5:0] slp;
        int use_src;
        t = tag_of(m);
        slp = {exp_mask(m), 1'b0};
        enter_sleep(m);
        check(t, slp);
        for (int j = 0; j < 4; j++) begin
            if (!exp_wake(m)[j]) begin
                wk = 4'b0001 << j;
                @(negedge clk);
                wk = '0;
                @(negedge clk);
                check("R10", slp);
            end
        end
        use_src = exp_wake(m)[3] ? 3 : 0;
        wk = 4'b0001 << use_src;
        @(negedge clk);
        wk = '0;
        if (m == 2 || m == 3) begin
            check("R11", {exp_mask(m) | 5'b00001, 1'b0});
            repeat (2) @(negedge clk);
            check("R11", {exp_mask(m) | 5'b00001, 1'b0});
            osc_ready = 1'b1;
            @(negedge clk);
            osc_ready = 1'b0;
            check("R11", 6'b111111);
        end else begin
            check("R12", 6'b111111);
        end
        @(negedge clk);
    endtask

    // Requests and mode changes while asleep; wake with ready already high.
    task automatic t_ignore_in_sleep();
        enter_sleep(2);
        sleep_req = 1'b1;
        mode_sel  = 3'b000;
        repeat (2) @(negedge clk);
        check("R13", 6'b000000);
        check("R2", 6'b000000);
        sleep_req = 1'b0;
        osc_ready = 1'b1;
        wk = 4'b0010;
        @(negedge clk);
        wk = '0;
        check("R11", 6'b000010);
        @(negedge clk);
        osc_ready = 1'b0;
        check("R11", 6'b111111);
        @(negedge clk);
    endtask

    // A request during the oscillator wait is not taken.
    task automatic t_req_in_wait();
        enter_sleep(3);
        wk = 4'b0001;
        @(negedge clk);
        wk = '0;
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        check("R2", 6'b000110);
        osc_ready = 1'b1;
        @(negedge clk);
        osc_ready = 1'b0;
        @(negedge clk);
        check("R2", 6'b111111);
    endtask

    task automatic t_reset_in_sleep();
        enter_sleep(1);
        check("R4", 6'b001110);
        rst = 1'b1;
        @(negedge clk);
        check("R1", 6'b111111);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 6'b111111);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_mode(0);
        t_mode(1);
        t_mode(2);
        t_mode(3);
        t_mode(6);
        t_mode(7);
        t_mode(4);
        t_mode(5);
        t_ignore_in_sleep();
        t_req_in_wait();
        t_reset_in_sleep();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, state %b expected done", obs());
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule